// File: doc/BRIEF.md
# Framebuffer-to-Panel Pixel Streamer

This block moves one complete frame of 16-bit pixels out of a local byte-wide framebuffer memory and onto the byte link of a display panel controller. Each byte on the link carries a data/command select bit. A frame always opens with a short header. The header sets the panel's column pointer and its row pointer to zero, each as a command byte followed by a data byte. It then sends the command that opens the panel's display-memory write port. After the header comes every pixel of the frame in linear order.

The framebuffer keeps each pixel with its low byte at the even address and its high byte at the odd address. The panel wants the high byte first. The streamer reads both bytes of a pixel in ascending address order and then sends them in swapped order. Reads go through a synchronous port with one cycle of latency. A small pixel buffer keeps the fetches running ahead of the link, so the link is never left idle while it is willing to accept bytes. A request to send a frame that arrives while a frame is already in progress is remembered. It starts exactly one further frame once the current frame ends.

The outgoing link is valid/ready. A byte moves on every rising edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the offered byte and its select bit stay frozen. `tx_ready` may be held low for any length of time. Frame geometry and pixel buffer depth are parameters; the default frame is 160 by 128 pixels.

Top module: `fb_stream_pusher`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `fb_rd` are all low.
- R2: Every frame opens with five link bytes, shown here as (select, value) with select 0 for a command and 1 for data: (0,0x20), (1,0x00), (0,0x21), (1,0x00), (0,0x22).
- R3: After the header, pixel p (from 0 to W*H-1) is sent as two bytes with select 1: first the framebuffer byte at address 2p+1, then the byte at address 2p.
- R4: Within a frame, the framebuffer is read exactly once at each address from 0 to 2*W*H-1, in ascending order. No more than PIX_DEPTH pixels are ever fetched ahead of the link. While the link is stalled in the header, exactly 2*PIX_DEPTH reads take place and then reads stop.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_dc` keep their values on the next cycle.
- R6: With `tx_ready` held high, the bytes of a frame are accepted on consecutive cycles, from the first header byte to the last pixel byte.
- R7: A `sync_req` seen while idle raises `busy` on the next cycle. `busy` stays high until the last byte of the frame is accepted and is low on the cycle after that acceptance, unless another frame follows. `tx_valid` and `fb_rd` are never high while `busy` is low.
- R8: Any number of `sync_req` pulses seen while `busy` is high produce exactly one further frame. This includes a pulse in the same cycle as the acceptance of the final byte. The further frame follows the current one without `busy` dropping.
- R9: `fb_addr` is always below 2*W*H when `fb_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_req | input | 1 | One-cycle request to send a frame |
| busy | output | 1 | High while a frame is being sent |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_addr | output | ADDR_W | Framebuffer byte address, valid with `fb_rd` |
| fb_data | input | 8 | Read data, valid the cycle after `fb_rd` |
| tx_valid | output | 1 | Link byte offered |
| tx_ready | input | 1 | Link accepts the offered byte on this edge |
| tx_data | output | 8 | Link byte value |
| tx_dc | output | 1 | Link byte select: 0 command, 1 data |

## Verification
The hardest case to reach from the ports is a new frame request that coincides with the end of a frame. This means a request in exactly the cycle the final pixel byte is accepted, or while that byte sits unaccepted. The bench has a ready mode that holds `tx_ready` low only on the last byte of a frame. This parks the streamer with its final byte pending. The bench then either issues the request during the hold or releases the hold and raises the request in the very same cycle. In both cases it counts that exactly one further frame follows. Ahead of that, a small frame is swept under always-ready, alternating and pseudo-random back-pressure. Every link byte and every read address is compared against values computed from the address arithmetic.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PIX,
    ST_DRAIN
  } fbs_state_e;

  localparam int HDR_LEN = 5;

  localparam logic [7:0] CMD_COL_PTR = 8'h20;
  localparam logic [7:0] CMD_ROW_PTR = 8'h21;
  localparam logic [7:0] CMD_MEM_PORT = 8'h22;

  typedef struct packed {
    logic       dc;
    logic [7:0] val;
  } link_byte_t;

  // Frame header: pointer writes to the origin, then the memory-port command (R2)
  function automatic link_byte_t hdr_entry(input logic [2:0] step);
    link_byte_t e;
    case (step)
      3'd0:    e = '{dc: 1'b0, val: CMD_COL_PTR};
      3'd1:    e = '{dc: 1'b1, val: 8'h00};
      3'd2:    e = '{dc: 1'b0, val: CMD_ROW_PTR};
      3'd3:    e = '{dc: 1'b1, val: 8'h00};
      default: e = '{dc: 1'b0, val: CMD_MEM_PORT};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/fbs_pix_fifo.sv
module fbs_pix_fifo #(
  parameter int DEPTH = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout  = slot[rp];
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/fbs_fetch.sv
module fbs_fetch #(
  parameter int NPIX   = 160 * 128,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              pop,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [7:0]        fb_data,
  output logic              push,
  output logic [15:0]       push_data
);
  localparam int IDX_W = $clog2(NPIX + 1);
  localparam int CRD_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] idx;
  logic             hi_ph;
  logic [CRD_W-1:0] resv;
  logic             lo_due, hi_due;
  logic [7:0]       lo_tmp;
  logic             issue_lo, issue_hi;

  // A pixel slot is reserved at its first read and freed when it leaves the buffer (R4)
  assign issue_lo = active && !hi_ph && (idx < IDX_W'(NPIX)) &&
                    ((resv < CRD_W'(DEPTH)) || pop);
  assign issue_hi = hi_ph;

  assign fb_rd     = issue_lo || issue_hi;
  assign fb_addr   = ADDR_W'({idx, hi_ph});
  assign push      = hi_due;
  assign push_data = {fb_data, lo_tmp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      hi_ph  <= 1'b0;
      resv   <= '0;
      lo_due <= 1'b0;
      hi_due <= 1'b0;
      lo_tmp <= '0;
    end else begin
      lo_due <= issue_lo;
      hi_due <= issue_hi;
      if (lo_due) lo_tmp <= fb_data;
      case ({issue_lo, pop})
        2'b10:   resv <= resv + 1'b1;
        2'b01:   resv <= resv - 1'b1;
        default: resv <= resv;
      endcase
      if (start) begin
        idx   <= '0;
        hi_ph <= 1'b0;
      end else if (issue_lo) begin
        hi_ph <= 1'b1;
      end else if (issue_hi) begin
        hi_ph <= 1'b0;
        idx   <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int NPIX = 160 * 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_req,
  output logic        busy,
  output logic        start,
  output logic        fetch_active,
  input  logic        pix_empty,
  input  logic [15:0] pix_data,
  output logic        pop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_dc
);
  localparam int IDX_W = $clog2(NPIX + 1);

  fbs_state_e       state;
  logic [2:0]       step;
  logic [IDX_W-1:0] sent;
  logic             lo_pend;
  logic [7:0]       lo_save;
  logic             pend;
  logic             slot_free;
  link_byte_t       hdr_b;

  assign slot_free    = !tx_valid || tx_ready;
  assign busy         = (state != ST_IDLE);
  assign fetch_active = (state == ST_HDR) || (state == ST_PIX);
  assign hdr_b        = hdr_entry(step);
  // A held request or one arriving with the final acceptance restarts at once (R8)
  assign start = ((state == ST_IDLE) && sync_req) ||
                 ((state == ST_DRAIN) && tx_ready && (pend || sync_req));
  assign pop   = (state == ST_PIX) && slot_free && !lo_pend && !pix_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      sent     <= '0;
      lo_pend  <= 1'b0;
      lo_save  <= '0;
      pend     <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_dc    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sync_req) state <= ST_HDR;
        end
        ST_HDR: begin
          if (slot_free) begin
            tx_valid <= 1'b1;
            tx_data  <= hdr_b.val;
            tx_dc    <= hdr_b.dc;
            if (step == 3'(HDR_LEN - 1)) state <= ST_PIX;
            else                         step  <= step + 1'b1;
          end
        end
        ST_PIX: begin
          if (slot_free) begin
            if (lo_pend) begin
              // second byte of the pixel: the lower memory address (R3)
              tx_valid <= 1'b1;
              tx_data  <= lo_save;
              tx_dc    <= 1'b1;
              lo_pend  <= 1'b0;
              if (sent == IDX_W'(NPIX)) state <= ST_DRAIN;
            end else if (!pix_empty) begin
              tx_valid <= 1'b1;
              tx_data  <= pix_data[15:8];
              tx_dc    <= 1'b1;
              lo_save  <= pix_data[7:0];
              lo_pend  <= 1'b1;
              sent     <= sent + 1'b1;
            end else begin
              tx_valid <= 1'b0;
            end
          end
        end
        default: begin
          // final byte on the link: busy falls once it is taken (R7)
          if (tx_ready) begin
            tx_valid <= 1'b0;
            state    <= start ? ST_HDR : ST_IDLE;
          end
        end
      endcase
      if (start) begin
        step    <= '0;
        sent    <= '0;
        lo_pend <= 1'b0;
        pend    <= 1'b0;
      end else if (sync_req && busy) begin
        pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fb_stream_pusher.sv
module fb_stream_pusher #(
  parameter int FRAME_W   = 160,
  parameter int FRAME_H   = 128,
  parameter int PIX_DEPTH = 2,
  parameter int ADDR_W    = $clog2(2 * FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_req,
  output logic              busy,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [7:0]        fb_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_dc
);
  localparam int NPIX = FRAME_W * FRAME_H;

  logic        start, fetch_active, pop, push, pix_empty;
  logic [15:0] push_data, pix_data;

  fbs_fetch #(.NPIX(NPIX), .ADDR_W(ADDR_W), .DEPTH(PIX_DEPTH)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .active    (fetch_active),
    .pop       (pop),
    .fb_rd     (fb_rd),
    .fb_addr   (fb_addr),
    .fb_data   (fb_data),
    .push      (push),
    .push_data (push_data)
  );

  fbs_pix_fifo #(.DEPTH(PIX_DEPTH), .DW(16)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_data),
    .pop   (pop),
    .dout  (pix_data),
    .empty (pix_empty)
  );

  fbs_seq #(.NPIX(NPIX)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_req     (sync_req),
    .busy         (busy),
    .start        (start),
    .fetch_active (fetch_active),
    .pix_empty    (pix_empty),
    .pix_data     (pix_data),
    .pop          (pop),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_dc        (tx_dc)
  );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int FRAME_W = 160,
  parameter int FRAME_H = 128,
  parameter int ADDR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_req,
  input logic              busy,
  input logic              fb_rd,
  input logic [ADDR_W-1:0] fb_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_dc
);
  localparam int LIM = 2 * FRAME_W * FRAME_H;

  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)     last_addr <= '0;
    else if (fb_rd) last_addr <= fb_addr;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_dc));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !fb_rd);

  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && sync_req |=> busy);

  assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> tx_valid && tx_data == 8'h20 && !tx_dc);

  assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd |-> {1'b0, fb_addr} < (ADDR_W + 1)'(LIM));

  assert_addr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd |-> (fb_addr == '0) || (fb_addr == last_addr + 1'b1));

endmodule

bind fb_stream_pusher fbs_checker #(
  .FRAME_W (FRAME_W),
  .FRAME_H (FRAME_H),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_req (sync_req),
  .busy     (busy),
  .fb_rd    (fb_rd),
  .fb_addr  (fb_addr),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_dc    (tx_dc)
);

// File: tb/fb_stream_pusher_test.sv
`timescale 1ns/1ps
module fb_stream_pusher_test;
  localparam int W  = 4;
  localparam int H  = 3;
  localparam int DP = 2;
  localparam int N  = W * H;
  localparam int NB = 5 + 2 * N;
  localparam int AW = $clog2(2 * N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_req = 1'b0;
  logic          busy, fb_rd, tx_valid, tx_dc;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_data, tx_data;
  logic          tx_ready = 1'b0;

  logic [7:0] mem [2 * N];
  logic [7:0] rdata = '0;

  int checks = 0, fails = 0, cyc = 0;
  int k = 0, frames = 0, reads = 0, rd_exp = 0, gaps = 0;
  int rmode = 0;
  bit hold_rel = 0, chk_fall = 1, after_last = 0;
  logic [7:0] lfsr = 8'h5b;

  fb_stream_pusher #(.FRAME_W(W), .FRAME_H(H), .PIX_DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .busy(busy),
    .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_dc(tx_dc)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (fb_rd && int'(fb_addr) < 2 * N) rdata <= mem[fb_addr];
  end
  assign fb_data = rdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_byte(input int idx);
    int j;
    case (idx)
      0: return 9'h020;
      1: return 9'h100;
      2: return 9'h021;
      3: return 9'h100;
      4: return 9'h022;
      default: begin
        j = idx - 5;
        if (j % 2 == 0) return 9'h100 | int'(mem[j + 1]);
        return 9'h100 | int'(mem[j - 1]);
      end
    endcase
  endfunction

  // link and read-port monitor; also drives tx_ready
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rmode)
        0: tx_ready = 1'b1;
        1: tx_ready = ~tx_ready;
        2: tx_ready = lfsr[0] & (lfsr[2] | lfsr[6]);
        3: tx_ready = 1'b0;
        default: tx_ready = (k == NB - 1 && tx_valid) ? hold_rel : 1'b1;
      endcase
      if (after_last) begin
        after_last = 0;
        if (chk_fall) chk(busy == 1'b0, "R7 busy low after last byte", int'(busy), 0);
      end
      if (rmode == 0 && k > 0 && !tx_valid) gaps++;
      if (fb_rd) begin
        chk(int'(fb_addr) == rd_exp, "R4 read address order", int'(fb_addr), rd_exp);
        rd_exp = (rd_exp == 2 * N - 1) ? 0 : rd_exp + 1;
        reads++;
      end
      if (tx_valid && tx_ready) begin
        chk(int'({tx_dc, tx_data}) == exp_byte(k), (k < 5) ? "R2 header byte" : "R3 pixel byte",
            int'({tx_dc, tx_data}), exp_byte(k));
        k++;
        if (k == NB) begin
          k = 0;
          frames++;
          after_last = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1;
    tick(1);
    sync_req = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      tick(1);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic wait_last_held();
    while (!(k == NB - 1 && tx_valid)) tick(1);
    tick(3);
  endtask

  initial begin
    int rbase;
    for (int i = 0; i < 2 * N; i++) mem[i] = 8'(i * 29 + 7);
    tick(3);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    chk(fb_rd == 1'b0, "R1 fb_rd", int'(fb_rd), 0);
    rst_n = 1'b1;
    tick(2);

    // always ready: continuity and busy rise
    rmode = 0;
    gaps = 0;
    sync_req = 1'b1;
    tick(1);
    sync_req = 1'b0;
    chk(busy == 1'b1, "R7 busy rises", int'(busy), 1);
    wait_idle();
    chk(frames == 1, "R3 frame count", frames, 1);
    chk(gaps == 0, "R6 no idle cycles", gaps, 0);
    chk(reads == 2 * N, "R4 reads per frame", reads, 2 * N);

    rmode = 1;
    pulse_sync();
    wait_idle();
    chk(frames == 2, "R5 alternating ready frame", frames, 2);

    rmode = 2;
    pulse_sync();
    wait_idle();
    chk(frames == 3, "R5 random ready frame", frames, 3);

    // stall at the first header byte
    rmode = 3;
    rbase = reads;
    pulse_sync();
    tick(20);
    chk(tx_valid == 1'b1, "R5 valid held", int'(tx_valid), 1);
    chk(int'({tx_dc, tx_data}) == 9'h020, "R5 byte held", int'({tx_dc, tx_data}), 9'h020);
    tick(7);
    chk(int'({tx_dc, tx_data}) == 9'h020, "R5 byte still held", int'({tx_dc, tx_data}), 9'h020);
    chk(fb_rd == 1'b0, "R4 reads stop when buffer full", int'(fb_rd), 0);
    chk(reads - rbase == 2 * DP, "R4 prefetch depth", reads - rbase, 2 * DP);
    rmode = 0;
    wait_idle();
    chk(frames == 4, "R5 stalled frame completes", frames, 4);

    // several requests during a frame -> one extra frame
    chk_fall = 0;
    pulse_sync();
    tick(6);
    pulse_sync();
    tick(4);
    pulse_sync();
    tick(9);
    pulse_sync();
    wait_idle();
    chk(frames == 6, "R8 one extra frame", frames, 6);
    tick(20);
    chk(busy == 1'b0 && frames == 6, "R8 no further frame", frames, 6);

    // request in the same cycle as the final acceptance
    rmode = 4;
    hold_rel = 0;
    pulse_sync();
    wait_last_held();
    chk(busy == 1'b1, "R7 busy while last byte held", int'(busy), 1);
    sync_req = 1'b1;
    hold_rel = 1;
    tick(1);
    sync_req = 1'b0;
    hold_rel = 0;
    rmode = 0;
    chk(busy == 1'b1, "R8 busy kept across frames", int'(busy), 1);
    wait_idle();
    chk(frames == 8, "R8 coincident request", frames, 8);

    // request while last byte is held
    rmode = 4;
    pulse_sync();
    wait_last_held();
    pulse_sync();
    tick(3);
    rmode = 0;
    wait_idle();
    chk(frames == 10, "R8 request during final hold", frames, 10);
    chk_fall = 1;

    rmode = 2;
    pulse_sync();
    wait_idle();
    chk(frames == 11, "R3 final random frame", frames, 11);
    chk(reads == 11 * 2 * N, "R4 total reads", reads, 11 * 2 * N);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule